// File: doc/BRIEF.md
# Host Memory Window Register Bridge

This block lets a host reach a word-organized memory inside the block through eight byte-wide registers. The host selects one register with a 3-bit offset and issues single-cycle read or write strobes with 8-bit data. Two registers hold a 15-bit byte address and a 2-bit access-mode field. Four registers are byte lanes of a 32-bit staging word. The remaining two are one-byte mailboxes, one for each direction, each with a pending flag.

In byte mode every lane access goes straight to one memory byte. In the 16-bit and 32-bit modes the lanes go through the staging word. Reading the first lane of a unit fetches that unit from memory, and writing the last lane of a unit stores it. The fourth mode also advances the word address every time lane 3 is touched. A host can therefore stream whole words with four byte accesses each. It handles unaligned head or tail bytes by switching to byte mode.

Top module: `hmw_bridge`

## Requirements
- R1: Offsets select registers as follows: 0 host-to-device mailbox, 1 device-to-host mailbox, 2 address low, 3 address high, 4 to 7 data lanes 0 to 3 (lane n is byte n, little-endian, of the word at the current word address). The host never raises read and write strobes in the same cycle.
- R2: Address low byte: bits 1:0 hold the mode (0 byte, 1 16-bit, 2 32-bit, 3 32-bit with auto-increment) and bits 7:2 hold address bits 7:2. Reading it returns the stored value. Both address registers reset to zero.
- R3: Address high byte bits 6:0 hold address bits 14:8. Bit 7 is not stored and reads as zero.
- R4: A host read strobe updates `h_rdata` at the next clock edge. `h_rdata` holds its value while no read strobe occurs and is zero after reset.
- R5: In mode 0, a read of lane n returns memory byte (word address + n), and a write of lane n changes only that byte.
- R6: In modes 2 and 3, a read of lane 0 loads the whole word at the current address into the staging word and returns its byte 0. Reads of lanes 1 to 3 return staged bytes.
- R7: In modes 2 and 3, writes of lanes 0 to 2 only stage their byte. A write of lane 3 stores all four staged bytes, with the new byte 3, to memory at one time.
- R8: In mode 3, any read or write of lane 3 advances the word address by one word (4 bytes) after the access, wrapping modulo 2^15. No other mode advances it.
- R9: In mode 1, a read of lane 0 or lane 2 loads the low or high halfword. A write of lane 1 or lane 3 stores the low or high halfword from the staged bytes. Other lane writes only stage.
- R10: A host write to offset 0 stores the byte on `dev_h2d_data` and sets `dev_h2d_pend`. A pulse on `dev_h2d_take` clears the flag.
- R11: A pulse on `dev_d2h_wr` stores `dev_d2h_data` for offset 1 and sets `h_d2h_pend`. A host read of offset 1 clears the flag unless a new device write occurs in the same cycle.
- R12: The memory holds MEM_WORDS 32-bit words (default 1024). Byte addresses alias modulo 4*MEM_WORDS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_off | input | 3 | Host register offset |
| h_rd | input | 1 | Host read strobe, one cycle |
| h_wr | input | 1 | Host write strobe, one cycle |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data, registered |
| h_d2h_pend | output | 1 | Device-to-host mailbox pending |
| dev_h2d_data | output | 8 | Host-to-device mailbox byte |
| dev_h2d_pend | output | 1 | Host-to-device mailbox pending |
| dev_h2d_take | input | 1 | Device acknowledges the host-to-device byte |
| dev_d2h_wr | input | 1 | Device writes the device-to-host mailbox |
| dev_d2h_data | input | 8 | Device-to-host mailbox byte |

## Verification
The assertions assume that the host never raises read and write in the same cycle, and one of them checks this. They also assume that every strobe lasts a single clock, so that each auto-increment and mailbox event is tied to exactly one access. The bench drives each strobe for one cycle from a task, from the falling edge to the next falling edge, and never combines the two strobes. It reads memory back only at bytes it has written earlier, because the array content is undefined after reset.

// File: rtl/hmw_pkg.sv
package hmw_pkg;
  localparam int ADDR_W  = 15;
  localparam int WADDR_W = ADDR_W - 2;

  typedef enum logic [1:0] {
    AM_BYTE     = 2'd0,
    AM_HALF     = 2'd1,
    AM_WORD     = 2'd2,
    AM_WORD_INC = 2'd3
  } amode_e;

  localparam logic [2:0] OFF_H2D   = 3'd0;
  localparam logic [2:0] OFF_D2H   = 3'd1;
  localparam logic [2:0] OFF_ADRLO = 3'd2;
  localparam logic [2:0] OFF_ADRHI = 3'd3;

  function automatic logic [7:0] get_byte(input logic [31:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction

  function automatic logic [31:0] put_byte(input logic [31:0] w, input logic [1:0] lane,
                                           input logic [7:0] b);
    logic [31:0] r;
    r = w;
    r[8*lane +: 8] = b;
    return r;
  endfunction

  function automatic logic [3:0] lane_onehot(input logic [1:0] lane);
    return 4'b0001 << lane;
  endfunction

  function automatic logic [WADDR_W-1:0] next_word(input logic [WADDR_W-1:0] w);
    return WADDR_W'(w + 1'b1);
  endfunction
endpackage

// File: rtl/hmw_mailbox.sv
module hmw_mailbox (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set,
  input  logic [7:0] set_data,
  input  logic       clr,
  output logic [7:0] data,
  output logic       pend
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data <= '0;
      pend <= 1'b0;
    end else if (set) begin
      data <= set_data;
      pend <= 1'b1;
    end else if (clr) begin
      pend <= 1'b0;
    end
  end
endmodule

// File: rtl/hmw_addr_reg.sv
module hmw_addr_reg
  import hmw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic [7:0]         wdata,
  input  logic               adv,
  output amode_e             mode,
  output logic [WADDR_W-1:0] waddr,
  output logic [7:0]         rd_lo,
  output logic [7:0]         rd_hi
);
  logic [7:0] lo_q;
  logic [6:0] hi_q;

  assign mode  = amode_e'(lo_q[1:0]);
  assign waddr = {hi_q, lo_q[7:2]};
  assign rd_lo = lo_q;
  assign rd_hi = {1'b0, hi_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_lo) begin
      lo_q <= wdata;
    end else if (wr_hi) begin
      hi_q <= wdata[6:0];
    end else if (adv) begin
      {hi_q, lo_q[7:2]} <= next_word(waddr);
    end
  end
endmodule

// File: rtl/hmw_datapath.sv
module hmw_datapath
  import hmw_pkg::*;
#(
  parameter int MEM_WORDS = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_rd,
  input  logic               acc_wr,
  input  logic [1:0]         lane,
  input  logic [7:0]         wdata,
  input  amode_e             mode,
  input  logic [WADDR_W-1:0] waddr,
  output logic [7:0]         rd_byte,
  output logic               fetch,
  output logic [3:0]         commit_be,
  output logic               adv
);
  localparam int IDX_W = (MEM_WORDS > 1) ? $clog2(MEM_WORDS) : 1;

  logic [31:0]      mem [MEM_WORDS];
  logic [31:0]      stage;
  logic [31:0]      mem_word;
  logic [31:0]      commit_word;
  logic [IDX_W-1:0] idx;
  logic             wide;

  assign idx      = IDX_W'(waddr);
  assign mem_word = mem[idx];
  assign wide     = (mode == AM_WORD) || (mode == AM_WORD_INC);
  assign fetch    = acc_rd && ((wide && lane == 2'd0) ||
                               (mode == AM_HALF && (lane == 2'd0 || lane == 2'd2)));
  assign adv      = (acc_rd || acc_wr) && mode == AM_WORD_INC && lane == 2'd3;
  assign rd_byte  = (mode == AM_BYTE || fetch) ? get_byte(mem_word, lane)
                                               : get_byte(stage, lane);

  always_comb begin
    commit_be   = 4'b0000;
    commit_word = {4{wdata}};
    if (acc_wr) begin
      unique case (mode)
        AM_BYTE: commit_be = lane_onehot(lane);
        AM_HALF: begin
          commit_word = put_byte(stage, lane, wdata);
          if (lane == 2'd1) commit_be = 4'b0011;
          if (lane == 2'd3) commit_be = 4'b1100;
        end
        default: begin
          commit_word = put_byte(stage, lane, wdata);
          if (lane == 2'd3) commit_be = 4'b1111;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage <= '0;
    end else if (acc_wr && mode != AM_BYTE) begin
      stage <= put_byte(stage, lane, wdata);
    end else if (fetch) begin
      if (wide)             stage        <= mem_word;
      else if (lane == 2'd0) stage[15:0]  <= mem_word[15:0];
      else                   stage[31:16] <= mem_word[31:16];
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (commit_be[l]) mem[idx][8*l +: 8] <= commit_word[8*l +: 8];
    end
  end
endmodule

// File: rtl/hmw_bridge.sv
module hmw_bridge
  import hmw_pkg::*;
#(
  parameter int MEM_WORDS = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] h_off,
  input  logic       h_rd,
  input  logic       h_wr,
  input  logic [7:0] h_wdata,
  output logic [7:0] h_rdata,
  output logic       h_d2h_pend,
  output logic [7:0] dev_h2d_data,
  output logic       dev_h2d_pend,
  input  logic       dev_h2d_take,
  input  logic       dev_d2h_wr,
  input  logic [7:0] dev_d2h_data
);
  amode_e             mode;
  logic [WADDR_W-1:0] waddr;
  logic [7:0]         adr_lo, adr_hi, d2h_byte, lane_byte, rd_mux;
  logic               is_lane, adv, fetch;
  logic [3:0]         commit_be;

  assign is_lane = h_off[2];

  hmw_mailbox u_h2d (
    .clk(clk), .rst_n(rst_n),
    .set(h_wr && h_off == OFF_H2D), .set_data(h_wdata),
    .clr(dev_h2d_take),
    .data(dev_h2d_data), .pend(dev_h2d_pend)
  );

  hmw_mailbox u_d2h (
    .clk(clk), .rst_n(rst_n),
    .set(dev_d2h_wr), .set_data(dev_d2h_data),
    .clr(h_rd && h_off == OFF_D2H),
    .data(d2h_byte), .pend(h_d2h_pend)
  );

  hmw_addr_reg u_addr (
    .clk(clk), .rst_n(rst_n),
    .wr_lo(h_wr && h_off == OFF_ADRLO),
    .wr_hi(h_wr && h_off == OFF_ADRHI),
    .wdata(h_wdata), .adv(adv),
    .mode(mode), .waddr(waddr), .rd_lo(adr_lo), .rd_hi(adr_hi)
  );

  hmw_datapath #(.MEM_WORDS(MEM_WORDS)) u_data (
    .clk(clk), .rst_n(rst_n),
    .acc_rd(h_rd && is_lane), .acc_wr(h_wr && is_lane),
    .lane(h_off[1:0]), .wdata(h_wdata),
    .mode(mode), .waddr(waddr),
    .rd_byte(lane_byte), .fetch(fetch), .commit_be(commit_be), .adv(adv)
  );

  always_comb begin
    unique case (h_off)
      OFF_H2D:   rd_mux = dev_h2d_data;
      OFF_D2H:   rd_mux = d2h_byte;
      OFF_ADRLO: rd_mux = adr_lo;
      OFF_ADRHI: rd_mux = adr_hi;
      default:   rd_mux = lane_byte;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    h_rdata <= '0;
    else if (h_rd) h_rdata <= rd_mux;
  end
endmodule

// File: rtl/hmw_checker.sv
module hmw_checker
  import hmw_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         h_off,
  input logic               h_rd,
  input logic               h_wr,
  input logic [7:0]         h_wdata,
  input logic [7:0]         h_rdata,
  input logic               h_d2h_pend,
  input logic [7:0]         dev_h2d_data,
  input logic               dev_h2d_pend,
  input logic               dev_d2h_wr,
  input amode_e             mode,
  input logic [WADDR_W-1:0] waddr,
  input logic               adv,
  input logic               fetch,
  input logic [3:0]         commit_be
);
  a_r1_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_rd && h_wr));

  a_r3_hi_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_off == OFF_ADRHI) |=> !h_rdata[7]);

  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !h_rd |=> $stable(h_rdata));

  a_r6_fetch_mode: assert property (@(posedge clk) disable iff (!rst_n)
    fetch |-> (mode != AM_BYTE && h_rd));

  a_r7_full_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_be == 4'b1111) |-> (h_wr && h_off == 3'd7 && mode inside {AM_WORD, AM_WORD_INC}));

  a_r8_adv_mode: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (mode == AM_WORD_INC && h_off == 3'd7));

  a_r8_adv_step: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (waddr == WADDR_W'($past(waddr) + 1'b1)));

  a_r10_h2d_set: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wr && h_off == OFF_H2D) |=> (dev_h2d_pend && dev_h2d_data == $past(h_wdata)));

  a_r11_d2h_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (h_rd && h_off == OFF_D2H && !dev_d2h_wr) |=> !h_d2h_pend);
endmodule

bind hmw_bridge hmw_checker u_chk (
  .clk(clk), .rst_n(rst_n), .h_off(h_off), .h_rd(h_rd), .h_wr(h_wr),
  .h_wdata(h_wdata), .h_rdata(h_rdata), .h_d2h_pend(h_d2h_pend),
  .dev_h2d_data(dev_h2d_data), .dev_h2d_pend(dev_h2d_pend),
  .dev_d2h_wr(dev_d2h_wr), .mode(mode), .waddr(waddr), .adv(adv),
  .fetch(fetch), .commit_be(commit_be)
);

// File: tb/tb_hmw_bridge.sv
module tb_hmw_bridge;
  localparam int MEMB = 4096;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] h_off = '0;
  logic       h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0] h_wdata = '0;
  logic [7:0] h_rdata;
  logic       h_d2h_pend;
  logic [7:0] dev_h2d_data;
  logic       dev_h2d_pend;
  logic       dev_h2d_take = 1'b0;
  logic       dev_d2h_wr = 1'b0;
  logic [7:0] dev_d2h_data = '0;

  int total = 0, bad = 0;
  logic [7:0] ref_mem [MEMB];
  logic       done = 1'b0;

  always #4 clk = ~clk;

  hmw_bridge dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk); h_off = off; h_wdata = d; h_wr = 1'b1;
    @(negedge clk); h_wr = 1'b0;
  endtask

  task automatic host_rd(input logic [2:0] off, output logic [7:0] d);
    @(negedge clk); h_off = off; h_rd = 1'b1;
    @(negedge clk); h_rd = 1'b0; d = h_rdata;
  endtask

  task automatic set_addr(input logic [14:0] a, input logic [1:0] m);
    host_wr(3'd2, {a[7:2], m});
    host_wr(3'd3, {1'b0, a[14:8]});
  endtask

  function automatic int ri(input int a);
    return a % MEMB;
  endfunction

  task automatic t_reset;
    logic [7:0] d;
    chk("R4 reset rdata", h_rdata, 0);
    chk("R10 reset pend", dev_h2d_pend, 0);
    chk("R11 reset pend", h_d2h_pend, 0);
    host_rd(3'd2, d); chk("R2 reset lo", d, 0);
    host_rd(3'd3, d); chk("R3 reset hi", d, 0);
  endtask

  task automatic t_addr_regs;
    logic [7:0] d;
    set_addr(15'h5A5C, 2'd1);
    host_rd(3'd2, d); chk("R2 lo readback", d, 8'h5D);
    host_rd(3'd3, d); chk("R3 hi readback", d, 8'h5A);
    host_wr(3'd3, 8'hFF);
    host_rd(3'd3, d); chk("R3 bit7 zero", d, 8'h7F);
    repeat (3) @(negedge clk);
    chk("R4 rdata held", h_rdata, 8'h7F);
  endtask

  task automatic t_byte;
    logic [7:0] d;
    set_addr(15'h0100, 2'd0);
    for (int l = 0; l < 4; l++) begin
      host_wr(3'(4 + l), 8'(8'h11 * (l + 1)));
      ref_mem[ri(16'h100 + l)] = 8'(8'h11 * (l + 1));
    end
    for (int l = 0; l < 4; l++) begin
      host_rd(3'(4 + l), d); chk("R5 byte lane read", d, ref_mem[ri(16'h100 + l)]);
    end
    set_addr(15'h1101, 2'd0);
    host_rd(3'd5, d); chk("R12 alias read", d, 8'h22);
    host_rd(3'd2, d); chk("R2 low bits masked", d, 8'h00);
  endtask

  task automatic t_word;
    logic [7:0] d;
    set_addr(15'h0200, 2'd0);
    for (int l = 0; l < 4; l++) begin
      host_wr(3'(4 + l), 8'(8'hA0 + l)); ref_mem[ri(16'h200 + l)] = 8'(8'hA0 + l);
    end
    set_addr(15'h0200, 2'd2);
    for (int l = 0; l < 3; l++) host_wr(3'(4 + l), 8'(l + 1));
    set_addr(15'h0200, 2'd0);
    for (int l = 0; l < 3; l++) begin
      host_rd(3'(4 + l), d); chk("R7 no store before lane3", d, ref_mem[ri(16'h200 + l)]);
    end
    set_addr(15'h0200, 2'd2);
    for (int l = 0; l < 4; l++) begin
      host_wr(3'(4 + l), 8'(8'hC0 + l)); ref_mem[ri(16'h200 + l)] = 8'(8'hC0 + l);
    end
    set_addr(15'h0200, 2'd0);
    for (int l = 0; l < 4; l++) begin
      host_rd(3'(4 + l), d); chk("R7 word stored", d, ref_mem[ri(16'h200 + l)]);
    end
    set_addr(15'h0100, 2'd2);
    for (int l = 0; l < 4; l++) begin
      host_rd(3'(4 + l), d); chk("R6 word fetch", d, ref_mem[ri(16'h100 + l)]);
    end
    host_rd(3'd2, d); chk("R8 no advance mode2", d, 8'h02);
    host_rd(3'd3, d); chk("R8 no advance mode2 hi", d, 8'h01);
  endtask

  task automatic t_half;
    logic [7:0] d;
    set_addr(15'h0300, 2'd0);
    for (int l = 0; l < 4; l++) begin
      host_wr(3'(4 + l), 8'(8'h50 + l)); ref_mem[ri(16'h300 + l)] = 8'(8'h50 + l);
    end
    set_addr(15'h0300, 2'd1);
    host_wr(3'd4, 8'hE0); host_wr(3'd5, 8'hE1);
    ref_mem[ri(16'h300)] = 8'hE0; ref_mem[ri(16'h301)] = 8'hE1;
    host_wr(3'd6, 8'hF2);
    set_addr(15'h0300, 2'd0);
    for (int l = 0; l < 4; l++) begin
      host_rd(3'(4 + l), d); chk("R9 low half stored only", d, ref_mem[ri(16'h300 + l)]);
    end
    set_addr(15'h0300, 2'd1);
    host_rd(3'd6, d); chk("R9 high half fetch", d, 8'h52);
    host_rd(3'd7, d); chk("R9 high half staged", d, 8'h53);
    host_rd(3'd2, d); chk("R8 no advance mode1", d, 8'h01);
  endtask

  task automatic t_burst;
    logic [7:0] d;
    set_addr(15'h0401, 2'd0);
    for (int l = 1; l < 4; l++) begin
      host_wr(3'(4 + l), 8'(8'h80 + l)); ref_mem[ri(16'h400 + l)] = 8'(8'h80 + l);
    end
    set_addr(15'h0404, 2'd3);
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 4; l++) begin
        host_wr(3'(4 + l), 8'(8'h90 + 4*w + l));
        ref_mem[ri(16'h404 + 4*w + l)] = 8'(8'h90 + 4*w + l);
      end
    host_rd(3'd2, d); chk("R8 advanced lo", d, 8'h0F);
    host_rd(3'd3, d); chk("R8 advanced hi", d, 8'h04);
    set_addr(15'h0404, 2'd3);
    for (int w = 0; w < 2; w++)
      for (int l = 0; l < 4; l++) begin
        host_rd(3'(4 + l), d); chk("R8 burst read", d, ref_mem[ri(16'h404 + 4*w + l)]);
      end
    set_addr(15'h0400, 2'd0);
    for (int l = 1; l < 4; l++) begin
      host_rd(3'(4 + l), d); chk("R5 head bytes", d, ref_mem[ri(16'h400 + l)]);
    end
  endtask

  task automatic t_wrap;
    logic [7:0] d;
    set_addr(15'h7FFC, 2'd3);
    for (int l = 0; l < 4; l++) begin
      host_wr(3'(4 + l), 8'(8'h71 + l)); ref_mem[ri(16'h7FFC + l)] = 8'(8'h71 + l);
    end
    host_rd(3'd2, d); chk("R8 wrap lo", d, 8'h03);
    host_rd(3'd3, d); chk("R8 wrap hi", d, 8'h00);
    set_addr(15'h0FFC, 2'd0);
    host_rd(3'd4, d); chk("R12 alias top word", d, ref_mem[ri(16'h7FFC)]);
  endtask

  task automatic t_mailbox;
    logic [7:0] d;
    host_wr(3'd0, 8'h3C);
    chk("R10 pend set", dev_h2d_pend, 1);
    chk("R10 data", dev_h2d_data, 8'h3C);
    host_rd(3'd0, d); chk("R1 h2d readback", d, 8'h3C);
    chk("R10 host read keeps pend", dev_h2d_pend, 1);
    @(negedge clk); dev_h2d_take = 1'b1;
    @(negedge clk); dev_h2d_take = 1'b0;
    chk("R10 pend cleared", dev_h2d_pend, 0);
    @(negedge clk); dev_d2h_data = 8'h96; dev_d2h_wr = 1'b1;
    @(negedge clk); dev_d2h_wr = 1'b0;
    chk("R11 pend set", h_d2h_pend, 1);
    host_rd(3'd1, d); chk("R11 data", d, 8'h96);
    chk("R11 pend cleared", h_d2h_pend, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_addr_regs();
    t_byte();
    t_word();
    t_half();
    t_burst();
    t_wrap();
    t_mailbox();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule